// File: doc/BRIEF.md
# Disk Write-Data Source Selector

This block decides what toggles the write-data flip-flop of a disk write channel, whose state goes out as a differential pair. While write gate is active it picks one of three sources. In normal operation the source is the coded bit stream from the encoder path. In raw byte mode, parallel NRZ bytes skip scrambling, 9-bit coding and precoding. They are serialised inside the block, and every 1 becomes a one-bit-clock return-to-zero pulse that flips the output. In external toggle mode, a single input pin flips the output with no synchroniser and no byte alignment.

The block also produces the byte clock from the bit clock. The period is nine bit clocks except in raw byte mode, where it shortens to eight bit clocks with three high. Raw byte mode latches each byte on the rising edge of this byte clock, so no separate write clock is needed. External toggle mode wins over raw byte mode. A raw byte request made while the nibble-wide host interface is selected is refused: the block stays in normal operation and raises a flag.

Top module: `wr_path_sel`

## Requirements
- R1: With write gate low, `path_mode` reads 0 (normal) whatever the mode requests. Encoding: 0 normal, 1 raw byte, 2 external toggle.
- R2: With write gate high and `dm2_sel_n` low, `path_mode` is 2 even when `dm1_ctl` is 1.
- R3: With write gate high, `dm2_sel_n` high, `dm1_ctl` 1 and `nibble_if` 1, `path_mode` is 0 and `dm1_reject` is 1. In every other case `dm1_reject` is 0.
- R4: In modes 0 and 2, `byte_clk` repeats with a period of 9 bit clocks and is high for the first 4 of them. After reset it starts high.
- R5: In mode 1, `byte_clk` repeats with a period of 8 bit clocks and is high for the first 3 of them.
- R6: In mode 1, the byte on `nrz_byte` in the last bit clock of a byte period is latched. Its bits are then applied MSB first, one per bit clock, starting at the rising edge of `byte_clk`. Each 1 flips `wd_p` once.
- R7: In mode 0 with write gate high, `wd_p` flips after each bit clock in which `enc_bit` is 1. `nrz_byte` and `dm2_data` have no effect.
- R8: In mode 2, `wd_p` flips after each bit clock in which `dm2_data` is 1. Only the toggle flip-flop lies between the pin and `wd_p`.
- R9: In the first bit clock in which write gate is high after being low, the toggle flip-flop is cleared, so `wd_p` is 0 after that edge.
- R10: While write gate is low, `wd_p` holds its value.
- R11: `wd_n` is always the complement of `wd_p`. Both reset to 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_gate | input | 1 | Write gate, active high |
| dm1_ctl | input | 1 | Raw byte mode request (control bit) |
| dm2_sel_n | input | 1 | External toggle mode request, active low |
| nibble_if | input | 1 | High when the nibble-wide host interface is selected |
| nrz_byte | input | BYTE_W | Parallel NRZ data for raw byte mode |
| enc_bit | input | 1 | Coded bit from the encoder path |
| dm2_data | input | 1 | External toggle input |
| byte_clk | output | 1 | Byte clock derived from the bit clock |
| wd_p | output | 1 | Write data, true side |
| wd_n | output | 1 | Write data, complement side |
| path_mode | output | 2 | Active source: 0 normal, 1 raw byte, 2 external toggle |
| dm1_reject | output | 1 | Raw byte request refused because of the nibble interface |

## Verification
The assertions assume that every input, including the external toggle pin, is synchronous to the bit clock and settled before each rising edge. The block adds no synchroniser, so it is correct only under that condition. The stimulus therefore changes every input shortly after a rising edge, samples outputs half a period later, and feeds `enc_bit` and `dm2_data` from a pseudo-random sequence. Mode switches are made at arbitrary points of a byte period. This checks that the counter wrap and the byte latch stay consistent when the period length changes mid-byte.

// File: rtl/wr_path_sel.sv
module wr_path_sel #(
  parameter int BYTE_W   = 8,
  parameter int NORM_DIV = 9,
  parameter int DM1_DIV  = 8,
  parameter int NORM_HI  = 4,
  parameter int DM1_HI   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_gate,
  input  logic              dm1_ctl,
  input  logic              dm2_sel_n,
  input  logic              nibble_if,
  input  logic [BYTE_W-1:0] nrz_byte,
  input  logic              enc_bit,
  input  logic              dm2_data,
  output logic              byte_clk,
  output logic              wd_p,
  output logic              wd_n,
  output logic [1:0]        path_mode,
  output logic              dm1_reject
);

  localparam int MAXDIV = (NORM_DIV > DM1_DIV) ? NORM_DIV : DM1_DIV;
  localparam int CW = $clog2(MAXDIV);
  localparam logic [1:0] MD_NORM = 2'd0;
  localparam logic [1:0] MD_DM1  = 2'd1;
  localparam logic [1:0] MD_DM2  = 2'd2;

  logic [CW-1:0]     cnt;
  logic [BYTE_W-1:0] sh;
  logic              wg_d;
  logic              tq;
  logic              tog;
  logic              dm1_req, dm2_req;
  logic [CW-1:0]     div_last, hi_len;

  assign dm2_req    = wr_gate & ~dm2_sel_n;
  assign dm1_req    = wr_gate & dm1_ctl;
  assign path_mode  = dm2_req ? MD_DM2 : ((dm1_req & ~nibble_if) ? MD_DM1 : MD_NORM);
  assign dm1_reject = dm1_req & nibble_if & ~dm2_req;

  assign div_last = (path_mode == MD_DM1) ? CW'(DM1_DIV - 1) : CW'(NORM_DIV - 1);
  assign hi_len   = (path_mode == MD_DM1) ? CW'(DM1_HI) : CW'(NORM_HI);
  assign byte_clk = cnt < hi_len;

  always_comb begin
    case (path_mode)
      MD_DM1:  tog = sh[BYTE_W-1];
      MD_DM2:  tog = dm2_data;
      default: tog = enc_bit;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sh   <= '0;
      wg_d <= 1'b0;
      tq   <= 1'b0;
    end else begin
      cnt  <= (cnt >= div_last) ? '0 : cnt + 1'b1;
      sh   <= (cnt == div_last) ? nrz_byte : {sh[BYTE_W-2:0], 1'b0};
      wg_d <= wr_gate;
      if (wr_gate && !wg_d)
        tq <= 1'b0;
      else if (wr_gate && tog)
        tq <= ~tq;
    end
  end

  assign wd_p = tq;
  assign wd_n = ~tq;

  // R9
  gate_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_gate && !wg_d) |=> !wd_p);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_gate |=> $stable(wd_p));

  // R8
  ext_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (path_mode == MD_DM2 && wg_d) |=> ((wd_p ^ $past(wd_p)) == $past(dm2_data)));

  // R3
  reject_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dm1_reject |-> (path_mode == MD_NORM));

  // R11
  diff_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_n == ~wd_p);

endmodule

// File: tb/tb_wr_path_sel.sv
module tb_wr_path_sel;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_gate = 0, dm1_ctl = 0, dm2_sel_n = 1, nibble_if = 0;
  logic [7:0] nrz_byte = 8'h00;
  logic enc_bit = 0, dm2_data = 0;
  logic byte_clk, wd_p, wd_n, dm1_reject;
  logic [1:0] path_mode;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [5:0] exp_q[$];
  string lab_q[$];

  // reference state
  int m_cnt = 0;
  logic m_q = 0;
  logic m_wgd = 0;
  logic [7:0] m_sr = 8'h00;
  logic [7:0] lf = 8'h5B;

  always #2 clk = ~clk;

  wr_path_sel dut (
    .clk(clk), .rst_n(rst_n), .wr_gate(wr_gate), .dm1_ctl(dm1_ctl),
    .dm2_sel_n(dm2_sel_n), .nibble_if(nibble_if), .nrz_byte(nrz_byte),
    .enc_bit(enc_bit), .dm2_data(dm2_data), .byte_clk(byte_clk),
    .wd_p(wd_p), .wd_n(wd_n), .path_mode(path_mode), .dm1_reject(dm1_reject)
  );

  task automatic step(input string lab, input logic g, input logic d1,
                      input logic d2n, input logic nib, input logic [7:0] nb);
    logic [1:0] m;
    logic f, bclk, tg;
    int per, hi;
    wr_gate = g; dm1_ctl = d1; dm2_sel_n = d2n; nibble_if = nib; nrz_byte = nb;
    enc_bit = lf[0]; dm2_data = lf[3];
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    if (g && !d2n) m = 2'd2;
    else if (g && d1 && !nib) m = 2'd1;
    else m = 2'd0;
    f = g && d2n && d1 && nib;
    per = (m == 2'd1) ? 8 : 9;
    hi = (m == 2'd1) ? 3 : 4;
    bclk = (m_cnt < hi);
    exp_q.push_back({m_q, ~m_q, bclk, m, f});
    lab_q.push_back(lab);
    tg = (m == 2'd1) ? m_sr[7] : ((m == 2'd2) ? dm2_data : enc_bit);
    if (g && !m_wgd) m_q = 0;
    else if (g && tg) m_q = ~m_q;
    m_wgd = g;
    m_sr = (m_cnt == per - 1) ? nb : {m_sr[6:0], 1'b0};
    m_cnt = (m_cnt >= per - 1) ? 0 : m_cnt + 1;
    @(posedge clk); #1;
  endtask

  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      logic [5:0] e, a;
      string l;
      e = exp_q.pop_front();
      l = lab_q.pop_front();
      a = {wd_p, wd_n, byte_clk, path_mode, dm1_reject};
      total++;
      if (a !== e) begin
        bad++;
        $display("FAIL %s: {wd_p,wd_n,byte_clk,mode,reject} got %b expected %b at %0t", l, a, e, $time);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;
    if ({wd_p, wd_n, byte_clk, path_mode, dm1_reject} !== 6'b011000) begin
      bad++;
      $display("FAIL R11 reset: got %b expected 011000",
               {wd_p, wd_n, byte_clk, path_mode, dm1_reject});
    end
    @(posedge clk); #1;
    rst_n = 1;
    // R1 R10: requests ignored, output held while gate low
    for (int i = 0; i < 18; i++) step("R1_R10 gate low", 0, i[0], i[1], 0, 8'hFF);
    // R7 R4: normal coded path
    for (int i = 0; i < 30; i++) step("R7_R4 normal", 1, 0, 1, 0, 8'(i * 37));
    // R10 hold after toggling
    for (int i = 0; i < 6; i++) step("R10 hold", 0, 0, 1, 0, 8'h00);
    // R9 clear on gate rise, then R5 R6 raw byte mode
    for (int i = 0; i < 48; i++) begin
      logic [7:0] b;
      case ((i / 8) % 4)
        0: b = 8'hA5;
        1: b = 8'hFF;
        2: b = 8'h00;
        default: b = 8'h93;
      endcase
      step(i == 0 ? "R9 gate rise" : "R5_R6 raw byte", 1, 1, 1, 0, b);
    end
    // R2 R8: external toggle wins over raw byte
    for (int i = 0; i < 24; i++) step("R2_R8 external", 1, 1, 0, 0, 8'hFF);
    // R3: raw byte refused with nibble interface
    for (int i = 0; i < 14; i++) step("R3 nibble reject", 1, 1, 1, 1, 8'hFF);
    // R3: external toggle with nibble set raises no flag
    for (int i = 0; i < 4; i++) step("R3 ext over nibble", 1, 1, 0, 1, 8'h00);
    // R9 second gate rise after a gap
    step("R9 gate drop", 0, 0, 1, 0, 8'h00);
    for (int i = 0; i < 10; i++) step("R9 regate", 1, 0, 1, 0, 8'h00);
    @(negedge clk); #1;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule